// File: doc/BRIEF.md
# UART Receive Character Queue with Trigger Interrupt

This block holds characters that a UART-style receiver has assembled, each kept together with its four per-character error bits. It can be switched at run time between two capacities. In queue mode it is a circular buffer of `DEPTH` entries (16 by default). In single mode it is one holding register. The write side takes a character either from the serial receiver or from an internal loopback source, chosen by a select input. The read side serves data-register reads from a bus. The head entry is always visible on `rd_word_o`, and a read strobe consumes it at the clock edge.

The block keeps registered empty and full flags. It reports the current fill level and the free space the receiver may still use. It raises a receive interrupt request when a write brings the fill level exactly to a programmable trigger count. The request drops when a read brings the level to one below that count.

On every read, the error bits of the returned character are captured in a status register. A clear strobe empties that register. A configuration write loads the trigger count and the mode bit. When the mode bit changes, the queue is flushed.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, the empty flag is 1, the full flag is 0, the level is 0, the space is 1, the interrupt request is 0 and the status is 0. The block starts in single mode (capacity 1) with a trigger count of 1.
- R2: A stored word has the data in bits [7:0] and error bits in bits [11:8]: framing in bit 8, parity in bit 9, break in bit 10 and overrun in bit 11. Words are returned in the order in which they were accepted.
- R3: Capacity is `DEPTH` in queue mode and 1 in single mode. The full flag is 1 exactly when the level equals the capacity, and `space_o` equals the capacity minus the level.
- R4: A write while full is dropped unless a read is taken in the same cycle, in which case the write is accepted.
- R5: A read while empty changes neither the level nor the read position. `rd_word_o` keeps showing the slot at the read position; in single mode, this is the last word held.
- R6: The empty flag sets when a read leaves the level at 0 and clears on any accepted write.
- R7: The interrupt request sets when an accepted write, with no read in the same cycle, makes the level equal to the trigger count.
- R8: The interrupt request clears when a read, with no write in the same cycle, makes the level plus one equal to the trigger count. In all other cases it keeps its value.
- R9: An accepted write and an effective read in the same cycle leave the level unchanged and keep the order of the stored words.
- R10: A configuration write always loads the trigger count. It flushes the queue (level 0, empty 1, full 0, write in that cycle dropped) only if the mode bit differs from the current mode.
- R11: Every read strobe, including one on an empty queue, copies bits [11:8] of `rd_word_o` into `stat_err_o`. `stat_clr_i` clears it, and a read in the same cycle takes precedence over the clear.
- R12: While `lb_sel_i` is 1, receiver writes are ignored and loopback writes are used. While it is 0, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_fifo_en_i | input | 1 | Mode bit for the write: 1 = queue mode, 0 = single mode |
| cfg_trig_i | input | CNT_W | Trigger count for the write |
| rx_push_i | input | 1 | Receiver write strobe |
| rx_word_i | input | W | Receiver word {err[3:0], data[7:0]} |
| lb_sel_i | input | 1 | Select the loopback source |
| lb_push_i | input | 1 | Loopback write strobe |
| lb_word_i | input | W | Loopback word |
| pop_i | input | 1 | Data-register read strobe |
| rd_word_o | output | W | Word at the read position |
| stat_clr_i | input | 1 | Clear strobe for the error status |
| stat_err_o | output | 4 | Error bits of the last read word |
| empty_o | output | 1 | Queue empty flag |
| full_o | output | 1 | Queue full flag |
| level_o | output | CNT_W | Number of stored words |
| space_o | output | CNT_W | Free slots for the receiver |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with `DEPTH` = 16, `DATA_W` = 8 and the loopback source included. This makes both capacities reachable and lets runs of more than sixteen writes and reads wrap the read position. In queue mode, the trigger is set to 4 so that the set and clear conditions of the interrupt request occur away from the empty and full edges. The single-mode runs cover full and empty reads on the one-slot register.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // error bits carried above the data bits of each entry
   localparam int ERR_W = 4;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 16,
   parameter int W     = 12,
   localparam int PTR_W = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             we_i,
   input  logic [PTR_W-1:0] waddr_i,
   input  logic [W-1:0]     wdata_i,
   input  logic [PTR_W-1:0] raddr_i,
   output logic [W-1:0]     rdata_o
);
   logic [DEPTH*W-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (we_i && (waddr_i == PTR_W'(i))) q <= wdata_i;
      end
      assign flat[i*W +: W] = q;
   end

   assign rdata_o = flat[raddr_i*W +: W];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             fifo_mode_i,
   input  logic             push_req_i,
   input  logic             pop_req_i,
   output logic             push_ok_o,
   output logic             pop_ok_o,
   output logic [PTR_W-1:0] wr_slot_o,
   output logic [PTR_W-1:0] rd_slot_o,
   output logic [CNT_W-1:0] count_o,
   output logic             empty_o,
   output logic             full_o,
   output logic [CNT_W-1:0] space_o
);
   logic [CNT_W-1:0] depth_eff;
   logic [PTR_W-1:0] mask;
   logic [PTR_W-1:0] rd_ptr_q;
   logic [CNT_W-1:0] count_q, count_nxt;
   logic             empty_q, full_q;

   assign depth_eff = fifo_mode_i ? CNT_W'(DEPTH) : CNT_W'(1);
   assign mask      = PTR_W'(depth_eff - CNT_W'(1));

   assign pop_ok_o  = pop_req_i && (count_q != '0) && !flush_i;
   assign push_ok_o = push_req_i && !flush_i && ((count_q != depth_eff) || pop_ok_o);

   assign wr_slot_o = (rd_ptr_q + PTR_W'(count_q)) & mask;
   assign rd_slot_o = rd_ptr_q;

   always_comb begin
      count_nxt = count_q;
      case ({push_ok_o, pop_ok_o})
         2'b10:   count_nxt = count_q + CNT_W'(1);
         2'b01:   count_nxt = count_q - CNT_W'(1);
         default: count_nxt = count_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         count_q  <= '0;
         empty_q  <= 1'b1;
         full_q   <= 1'b0;
      end else if (flush_i) begin
         rd_ptr_q <= '0;
         count_q  <= '0;
         empty_q  <= 1'b1;
         full_q   <= 1'b0;
      end else begin
         count_q <= count_nxt;
         if (pop_ok_o) rd_ptr_q <= (rd_ptr_q + PTR_W'(1)) & mask;
         if (push_ok_o) empty_q <= 1'b0;
         else if (pop_ok_o && count_nxt == '0) empty_q <= 1'b1;
         if (pop_req_i) full_q <= 1'b0;
         if (push_ok_o && count_nxt == depth_eff) full_q <= 1'b1;
      end
   end

   assign count_o = count_q;
   assign empty_o = empty_q;
   assign full_o  = full_q;
   assign space_o = depth_eff - count_q;

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= depth_eff);
   // R4
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req_i && !pop_req_i && !flush_i && count_q == depth_eff) |=> $stable(count_q));
   // R5
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req_i && !push_req_i && !flush_i && count_q == '0) |=> (count_q == '0 && $stable(rd_ptr_q)));
   // R9
   pushpop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok_o && pop_ok_o) |=> $stable(count_q));
   // R6
   empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok_o && !push_ok_o && count_q == CNT_W'(1)) |=> empty_q);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
   parameter int CNT_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_ok_i,
   input  logic             pop_ok_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] trig_i,
   output logic             irq_o
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else if (push_ok_i && !pop_ok_i && (count_i + CNT_W'(1)) == trig_i) irq_q <= 1'b1;
      else if (pop_ok_i && !push_ok_i && count_i == trig_i) irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   // R7
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> (count_i == $past(trig_i)));
   // R8
   irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> (CNT_W'(count_i + CNT_W'(1)) == $past(trig_i)));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
   parameter int DEPTH        = 16,
   parameter int DATA_W       = 8,
   parameter bit HAS_LOOPBACK = 1'b1,
   localparam int W     = DATA_W + rxq_pkg::ERR_W,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_wr_i,
   input  logic                      cfg_fifo_en_i,
   input  logic [CNT_W-1:0]          cfg_trig_i,
   input  logic                      rx_push_i,
   input  logic [W-1:0]              rx_word_i,
   input  logic                      lb_sel_i,
   input  logic                      lb_push_i,
   input  logic [W-1:0]              lb_word_i,
   input  logic                      pop_i,
   output logic [W-1:0]              rd_word_o,
   input  logic                      stat_clr_i,
   output logic [rxq_pkg::ERR_W-1:0] stat_err_o,
   output logic                      empty_o,
   output logic                      full_o,
   output logic [CNT_W-1:0]          level_o,
   output logic [CNT_W-1:0]          space_o,
   output logic                      irq_o
);
   initial begin
      param_chk: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0 && DATA_W >= 1)
         else $error("uart_rx_queue: DEPTH must be a power of two >= 2");
   end

   logic             fifo_en_q;
   logic [CNT_W-1:0] trig_q;
   logic             flush;
   logic             src_push;
   logic [W-1:0]     src_word;
   logic             push_ok, pop_ok;
   logic [PTR_W-1:0] wr_slot, rd_slot;
   logic [CNT_W-1:0] count;
   logic [rxq_pkg::ERR_W-1:0] stat_q;

   assign flush = cfg_wr_i && (cfg_fifo_en_i != fifo_en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en_q <= 1'b0;
         trig_q    <= CNT_W'(1);
      end else if (cfg_wr_i) begin
         fifo_en_q <= cfg_fifo_en_i;
         trig_q    <= cfg_trig_i;
      end
   end

   if (HAS_LOOPBACK) begin : g_lb
      assign src_push = lb_sel_i ? lb_push_i : rx_push_i;
      assign src_word = lb_sel_i ? lb_word_i : rx_word_i;
   end else begin : g_nolb
      assign src_push = rx_push_i;
      assign src_word = rx_word_i;
   end

   rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .fifo_mode_i(fifo_en_q),
      .push_req_i(src_push), .pop_req_i(pop_i),
      .push_ok_o(push_ok), .pop_ok_o(pop_ok),
      .wr_slot_o(wr_slot), .rd_slot_o(rd_slot), .count_o(count),
      .empty_o(empty_o), .full_o(full_o), .space_o(space_o)
   );

   rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
      .clk(clk), .we_i(push_ok), .waddr_i(wr_slot), .wdata_i(src_word),
      .raddr_i(rd_slot), .rdata_o(rd_word_o)
   );

   rxq_irq #(.CNT_W(CNT_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .push_ok_i(push_ok), .pop_ok_i(pop_ok),
      .count_i(count), .trig_i(trig_q), .irq_o(irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else if (pop_i) stat_q <= rd_word_o[W-1 -: rxq_pkg::ERR_W];
      else if (stat_clr_i) stat_q <= '0;
   end

   assign stat_err_o = stat_q;
   assign level_o    = count;

   // R11
   stat_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> (stat_err_o == $past(rd_word_o[W-1 -: rxq_pkg::ERR_W])));
   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level_o == '0 && empty_o && !full_o));
endmodule

// File: tb/uart_rx_queue_bench.sv
module uart_rx_queue_bench;
   localparam int DEPTH = 16;
   localparam int CNT_W = 5;
   localparam int W     = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_en = 1'b0;
   logic [CNT_W-1:0] cfg_trig = '0;
   logic rx_push = 1'b0, lb_sel = 1'b0, lb_push = 1'b0, pop = 1'b0, clr = 1'b0;
   logic [W-1:0] rx_word = '0, lb_word = '0, rd_word;
   logic [3:0] stat;
   logic empty, full, irq;
   logic [CNT_W-1:0] level, space;

   always #10 clk = ~clk;

   uart_rx_queue #(.DEPTH(DEPTH), .DATA_W(8), .HAS_LOOPBACK(1'b1)) u_uart_rx_queue (
      .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_fifo_en_i(cfg_en),
      .cfg_trig_i(cfg_trig), .rx_push_i(rx_push), .rx_word_i(rx_word),
      .lb_sel_i(lb_sel), .lb_push_i(lb_push), .lb_word_i(lb_word),
      .pop_i(pop), .rd_word_o(rd_word), .stat_clr_i(clr), .stat_err_o(stat),
      .empty_o(empty), .full_o(full), .level_o(level), .space_o(space), .irq_o(irq)
   );

   int n_chk = 0, n_fail = 0;
   logic [W-1:0] exp_q[$];
   logic m_en = 1'b0;
   int   m_trig = 1;
   logic m_irq = 1'b0;
   logic [3:0] m_stat = '0;
   logic m_stat_ok = 1'b1;
   logic [W-1:0] m_last = '0;
   logic m_stale_ok = 1'b0;

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected words and compares with the head seen by the read
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (rst_n && pop) begin
            if (exp_q.size() > 0) begin
               automatic logic [W-1:0] w = exp_q.pop_front();
               chk(rd_word === w, "R2/R9 word order", int'(rd_word), int'(w));
               m_last = w; m_stat = w[11:8]; m_stat_ok = 1'b1;
               m_stale_ok = !m_en;
            end else if (m_stale_ok) begin
               chk(rd_word === m_last, "R5 stale empty read", int'(rd_word), int'(m_last));
               m_stat = m_last[11:8]; m_stat_ok = 1'b1;
            end else m_stat_ok = 1'b0;
         end
      end
   end

   task automatic check_state(input string req);
      automatic int cap = m_en ? DEPTH : 1;
      automatic int n = exp_q.size();
      chk(level == CNT_W'(n), {req, " level"}, int'(level), n);
      chk(empty == (n == 0), {req, " empty"}, int'(empty), int'(n == 0));
      chk(full == (n == cap), {req, " R3 full"}, int'(full), int'(n == cap));
      chk(space == CNT_W'(cap - n), {req, " R3 space"}, int'(space), cap - n);
      chk(irq == m_irq, {req, " irq"}, int'(irq), int'(m_irq));
      if (m_stat_ok) chk(stat == m_stat, {req, " R11 status"}, int'(stat), int'(m_stat));
   endtask

   // driver: one cycle of stimulus, model update after the edge
   task automatic step(input logic rp, input logic [W-1:0] rw, input logic ls,
                       input logic lp, input logic [W-1:0] lw, input logic pp,
                       input logic cl, input string req);
      automatic int cap, n;
      automatic logic eff_p, acc, pok;
      automatic logic [W-1:0] eff_w;
      @(negedge clk);
      rx_push = rp; rx_word = rw; lb_sel = ls; lb_push = lp; lb_word = lw;
      pop = pp; clr = cl;
      cap = m_en ? DEPTH : 1;
      n = exp_q.size();
      eff_p = ls ? lp : rp;
      eff_w = ls ? lw : rw;
      pok = pp && (n > 0);
      acc = eff_p && ((n < cap) || pok);
      if (acc && !pok && (n + 1) == m_trig) m_irq = 1'b1;
      else if (pok && !acc && n == m_trig) m_irq = 1'b0;
      @(posedge clk);
      #1;
      if (acc) exp_q.push_back(eff_w);
      if (cl && !pp) begin m_stat = '0; m_stat_ok = 1'b1; end
      rx_push = 1'b0; lb_push = 1'b0; pop = 1'b0; clr = 1'b0;
      check_state(req);
   endtask

   task automatic push(input logic [W-1:0] w, input string req);
      step(1'b1, w, 1'b0, 1'b0, '0, 1'b0, 1'b0, req);
   endtask

   task automatic rd(input string req);
      step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0, req);
   endtask

   task automatic cfg(input logic en, input int trig, input string req);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_en = en; cfg_trig = CNT_W'(trig);
      @(posedge clk);
      #1;
      cfg_wr = 1'b0;
      if (en != m_en) begin exp_q.delete(); m_stale_ok = 1'b0; end
      m_en = en; m_trig = trig;
      check_state(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_state("R1 reset");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check_state("R1 after release");

      // single mode, trigger 1
      push(12'h541, "R7 single push sets irq");
      push(12'h8AA, "R4 single full push dropped");
      rd("R8 single read clears irq");
      rd("R5 empty read no change");
      step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R11 status clear");
      push(12'h311, "R6 push clears empty");
      step(1'b1, 12'h722, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R4 single full push with read");
      cfg(1'b1, 4, "R10 mode change flushes");

      // queue mode, trigger 4
      for (int i = 0; i < 16; i++) push(12'((i % 16) << 8) | 12'(8'h30 + i), "R7 fill");
      push(12'hF99, "R4 queue full push dropped");
      step(1'b1, 12'h1AB, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R4 R9 full push with read");
      for (int i = 0; i < 12; i++) rd("R8 drain above trigger");
      rd("R8 level drops below trigger");
      rd("R8 no change below trigger");
      push(12'h2C1, "R7 below trigger");
      push(12'h4C2, "R7 reaches trigger again");
      step(1'b1, 12'h8C3, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R9 push and read at trigger");
      step(1'b1, 12'h0EE, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R12 receiver ignored in loopback");
      step(1'b0, '0, 1'b1, 1'b1, 12'h5DD, 1'b0, 1'b0, "R12 loopback write");
      step(1'b0, '0, 1'b0, 1'b1, 12'h6DD, 1'b0, 1'b0, "R12 loopback ignored when deselected");
      cfg(1'b1, 2, "R10 same mode keeps contents");
      step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R11 read wins over clear");
      for (int i = 0; i < 40 && exp_q.size() > 0; i++) rd("R2 drain in order");
      for (int i = 0; i < 20; i++)
         step(1'b1, 12'(i * 37), 1'b0, 1'b0, '0, (i % 3) != 0, 1'b0, "R9 wrap traffic");
      cfg(1'b0, 1, "R10 flush back to single");
      push(12'h9F0, "R3 single capacity");
      rd("R2 single read");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule